// File: doc/BRIEF.md
# Bus Hold Arbitration Controller

This block lends the local bus to an outside master through a level request and acknowledge pair. The outside master raises its request line, waits until the acknowledge output goes high, and only then drives address, data and control. While the acknowledge is high, the local bus outputs are released to high impedance through a float output, and the local sequencer is told to hold off.

The request arrives asynchronously and first crosses a chain of synchronizer flops. A grant is never cut into a running transfer. The controller waits for the sequencer to report the last state of its current bus cycle, or to report that it is idle. Withdrawing the request clears the grant at the next rising edge. The acknowledge is then stretched so that it falls on the following falling edge. The sequencer resumes at the rising edge after that.

Top module: `hold_arbiter`

## Requirements
- R1: While rst_ni is low, hlda_o, float_o and suspend_o are all low.
- R2: The request passes through SYNC_STAGES rising-edge flops (default 2). With the sequencer idle, suspend_o is high after the 2nd rising edge following a rise of hold_i, and hlda_o is high after the 3rd.
- R3: While a cycle is running (seq_idle_i and cyc_end_i both low), no grant is given. hlda_o rises at the first rising edge at which cyc_end_i is sampled high with the synchronized request high.
- R4: If seq_idle_i is sampled high together with the synchronized request, hlda_o is high after that same rising edge.
- R5: After hold_i falls, hlda_o stays high through the 3rd rising edge. It goes low at the falling edge that follows that rising edge.
- R6: float_o is high exactly when hlda_o is high.
- R7: suspend_o is high whenever the synchronized request is high or hlda_o is high. It goes low together with hlda_o once the request is gone.
- R8: A request withdrawn before a grant point produces no grant, and suspend_o returns low.
- R9: While the request stays high after a grant, hlda_o stays high whatever seq_idle_i and cyc_end_i do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; request sampled on rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Asynchronous bus request from the outside master |
| seq_idle_i | input | 1 | Local sequencer has no bus cycle in progress |
| cyc_end_i | input | 1 | Local sequencer is in the last state of its bus cycle |
| hlda_o | output | 1 | Bus granted to the outside master |
| float_o | output | 1 | Tri-state enable for all local address, data and control drivers |
| suspend_o | output | 1 | Local sequencer must not start a new cycle |

## Verification
The assertions assume three things about the inputs. cyc_end_i is high for a single cycle, and only as a running cycle ends. hold_i is a level that the outside master keeps until it has seen the acknowledge. seq_idle_i and cyc_end_i change only between rising edges. The stimulus drives every input just after a falling edge. It raises cyc_end_i no earlier than the edge on which the synchronized request is first visible. It also holds hold_i steady for whole cycles, including a single-cycle withdrawal used to exercise the no-grant path.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;
  localparam int unsigned MIN_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ARB_RUN   = 2'd0,
    ARB_WAIT  = 2'd1,
    ARB_GRANT = 2'd2
  } arb_state_e;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    for (genvar g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/hold_grant_fsm.sv
module hold_grant_fsm
  import hold_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_s_i,
  input  logic seq_idle_i,
  input  logic cyc_end_i,
  output logic grant_o
);
  arb_state_e state_q, state_d;
  logic       boundary;

  // grant point: end of current cycle or nothing running
  assign boundary = cyc_end_i | seq_idle_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_RUN, ARB_WAIT: begin
        if (!hold_s_i)     state_d = ARB_RUN;
        else if (boundary) state_d = ARB_GRANT;
        else               state_d = ARB_WAIT;
      end
      ARB_GRANT: begin
        if (!hold_s_i)     state_d = ARB_RUN;
      end
      default:             state_d = ARB_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ARB_RUN;
    else         state_q <= state_d;
  end

  assign grant_o = (state_q == ARB_GRANT);

  // R3
  grant_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> $past(cyc_end_i || seq_idle_i));

  // R9
  hold_keeps_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && hold_s_i) |=> grant_o);

  // R5
  drop_ends_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !hold_s_i) |=> !grant_o);

  // R8
  withdraw_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grant_o && !hold_s_i) |=> !grant_o);
endmodule

// File: rtl/hold_release_stretch.sv
module hold_release_stretch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  output logic hlda_o
);
  logic tail_q;

  // falling-edge copy keeps the acknowledge up for the half cycle after release
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tail_q <= 1'b0;
    else         tail_q <= grant_i;
  end

  assign hlda_o = grant_i | tail_q;
endmodule

// File: rtl/hold_arbiter.sv
module hold_arbiter
  import hold_arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic seq_idle_i,
  input  logic cyc_end_i,
  output logic hlda_o,
  output logic float_o,
  output logic suspend_o
);
  localparam int unsigned STAGES_USED =
    (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic hold_s;
  logic grant;
  logic ack;

  hold_sync #(.STAGES(STAGES_USED)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (hold_i),
    .q_o    (hold_s)
  );

  hold_grant_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_s_i   (hold_s),
    .seq_idle_i (seq_idle_i),
    .cyc_end_i  (cyc_end_i),
    .grant_o    (grant)
  );

  hold_release_stretch i_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .grant_i (grant),
    .hlda_o  (ack)
  );

  assign hlda_o    = ack;
  assign float_o   = ack;
  assign suspend_o = ack | hold_s;

  // R4
  idle_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_s && seq_idle_i) |=> hlda_o);
endmodule

// File: tb/test_hold_arbiter.sv
module test_hold_arbiter;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hold_i = 1'b0;
  logic seq_idle_i = 1'b1;
  logic cyc_end_i = 1'b0;
  logic hlda_o, float_o, suspend_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  hold_arbiter i_hold_arbiter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (hold_i),
    .seq_idle_i (seq_idle_i),
    .cyc_end_i  (cyc_end_i),
    .hlda_o     (hlda_o),
    .float_o    (float_o),
    .suspend_o  (suspend_o)
  );

  typedef struct packed {
    logic       idle; // sequencer idle throughout
    logic [7:0] k;    // rising edge (after hold_i rises) of the grant
    logic [7:0] h;    // cycles hold kept after grant check window
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b1, 8'd3, 8'd2},
    '{1'b0, 8'd3, 8'd1},
    '{1'b0, 8'd5, 8'd3},
    '{1'b0, 8'd9, 8'd0},
    '{1'b1, 8'd3, 8'd6}
  };

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pos();
    @(posedge clk_i); #2;
  endtask

  task automatic neg();
    @(negedge clk_i); #1;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) pos();
    chk(hlda_o, 0, "R1 hlda");
    chk(float_o, 0, "R1 float");
    chk(suspend_o, 0, "R1 suspend");
    neg(); rst_ni = 1'b1;
    repeat (2) pos();
    chk(hlda_o, 0, "R1 hlda after release");

    // vector table walk
    foreach (VECS[v]) begin
      neg();
      hold_i = 1'b1; seq_idle_i = VECS[v].idle; cyc_end_i = 1'b0;
      for (int e = 1; e <= int'(VECS[v].k) + 1; e++) begin
        pos();
        chk(hlda_o, (e >= int'(VECS[v].k)) ? 1 : 0, VECS[v].idle ? "R4 R2 grant timing" : "R3 grant at cycle end");
        chk(suspend_o, (e >= 2) ? 1 : 0, "R2 R7 suspend timing");
        chk(float_o, hlda_o, "R6 float");
        neg();
        cyc_end_i = (e + 1 == int'(VECS[v].k)) && !VECS[v].idle;
      end
      for (int h = 0; h < int'(VECS[v].h); h++) begin
        pos();
        chk(hlda_o, 1, "R9 held grant");
        neg();
        seq_idle_i = ~seq_idle_i;
        cyc_end_i  = ~cyc_end_i;
      end
      hold_i = 1'b0; cyc_end_i = 1'b0;
      for (int r = 1; r <= 3; r++) begin
        pos();
        chk(hlda_o, 1, "R5 hlda before release edge");
        chk(suspend_o, 1, "R7 suspend during release");
      end
      neg();
      chk(hlda_o, 0, "R5 hlda falls on falling edge");
      chk(float_o, 0, "R6 float released");
      chk(suspend_o, 0, "R7 suspend released");
      seq_idle_i = 1'b1;
      repeat (2) pos();
    end

    // R8 withdrawn request, busy sequencer
    neg(); seq_idle_i = 1'b0; hold_i = 1'b1;
    pos();
    neg(); hold_i = 1'b0;
    pos();
    chk(suspend_o, 1, "R8 suspend while request seen");
    for (int e = 3; e <= 8; e++) begin
      pos();
      chk(hlda_o, 0, "R8 no grant");
      if (e >= 4) chk(suspend_o, 0, "R8 suspend dropped");
    end
    neg(); seq_idle_i = 1'b1; cyc_end_i = 1'b1;
    pos();
    neg(); cyc_end_i = 1'b0;
    repeat (2) pos();
    chk(hlda_o, 0, "R8 no late grant");

    // R1 reset during grant
    neg(); hold_i = 1'b1;
    repeat (4) pos();
    chk(hlda_o, 1, "R4 grant before reset");
    neg(); rst_ni = 1'b0;
    #1;
    chk(hlda_o, 0, "R1 reset clears hlda");
    chk(suspend_o, 0, "R1 reset clears suspend");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule